// File: doc/BRIEF.md
# Eight-Slot TDM Audio Framer

This block runs a time-division-multiplexed audio port that moves eight playback channels in and eight capture channels out, each direction on a single data line. It works from one master clock at 512 times the frame rate. From that clock it derives the TDM bit clock (256 bit periods per frame), a one-bit-wide frame sync and, acting as master, the bit and frame clocks for three external stereo converters that deliver their samples as ordinary I2S streams at 64 bit periods per frame.

Playback words are deserialized from the TDM input and published on parallel ports once per frame. On the capture side, one internal stereo pair is taken from parallel inputs and the three auxiliary I2S streams are gathered, and all eight words are re-serialized into the next TDM frame. In both directions the slot order puts every left channel first and every right channel after it. Each 24-bit sample sits at the top of a 32-bit slot.

Top module: `tdm8_framer`

## Requirements
- R1: `tdm_fsync` is high for exactly one TDM bit period in every 256. That period is bit 255, the one just before the MSB of slot 0.
- R2: `tdm_dout` changes only when `tdm_bclk` rises and is stable for the whole bit period. `tdm_din` is sampled when `tdm_bclk` falls.
- R3: `aux_bclk` has 64 rising edges per frame (master clock / 8). `aux_lrclk` has a period of one frame (master clock / 512). It is low during TDM bits 0-127 and high during bits 128-255, and it changes only together with a falling edge of `aux_bclk`.
- R4: Bit k of a frame lies in slot k/32 (slots 0-7). Playback slot s carries, MSB first in its first 24 bit periods, left channel s+1 when s<4 and right channel s-3 when s>=4. Left channel p+1 appears on `play_l[p*24 +: 24]` and right channel p+1 on `play_r[p*24 +: 24]`. Bits 24-31 of each slot are ignored.
- R5: Capture slots 0 and 4 carry `cap_int_l` and `cap_int_r`. Slots 1-3 carry the left words of `aux_sd[0]`, `aux_sd[1]` and `aux_sd[2]`, and slots 5-7 carry their right words. Each word fills the first 24 bit periods of its slot, MSB first.
- R6: Bits 24-31 of every capture slot are driven as 0.
- R7: Capture data collected during one frame is sent in the following frame. `cap_int_l`/`cap_int_r` are sampled once per frame, at the rising edge of `tdm_fsync`, so a change during a frame does not reach the frame in progress.
- R8: `play_l` and `play_r` change only at the rising edge of `tdm_fsync`. At that edge they take the words of the frame just received and hold them through the whole next frame.
- R9: An auxiliary input delivers its left word while `aux_lrclk` is low and its right word while it is high. The MSB is in the second `aux_bclk` period after the `aux_lrclk` edge, and 24 bits are sampled on rising `aux_bclk`. The remaining bits of each half are ignored.
- R10: While reset is active, `tdm_bclk` is high and `tdm_fsync`, `tdm_dout`, `aux_bclk`, `aux_lrclk`, `play_l` and `play_r` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 512 times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdm_bclk | output | 1 | TDM bit clock, 256 periods per frame |
| tdm_fsync | output | 1 | Frame sync pulse, one bit period wide |
| tdm_din | input | 1 | TDM playback serial data |
| tdm_dout | output | 1 | TDM capture serial data |
| aux_bclk | output | 1 | Auxiliary I2S bit clock, 64 periods per frame |
| aux_lrclk | output | 1 | Auxiliary I2S word clock, low for left |
| aux_sd | input | 3 | Serial data from the three auxiliary stereo sources |
| cap_int_l | input | 24 | Internal capture pair, left word |
| cap_int_r | input | 24 | Internal capture pair, right word |
| play_l | output | 96 | Left playback words, channel 1 in the low 24 bits |
| play_r | output | 96 | Right playback words, channel 1 in the low 24 bits |

## Verification
The checker watches every cycle for four rules: the spacing and width of the frame sync, capture data moving only on a rising TDM bit clock, the auxiliary word clock turning only on a falling auxiliary bit clock, and the parallel playback words holding between frame syncs. Slot order, the left-then-right arrangement, zero padding, the MSB position in the I2S halves and the one-frame delay of capture data depend on the values carried. Only the directed scenarios show these. They drive whole frames and auxiliary streams with known words, including full-scale codes and non-zero junk in the pad bits.

// File: rtl/tdm8_pkg.sv
package tdm8_pkg;
  localparam int unsigned TDM8_SAMPLE_W = 24;
  localparam int unsigned TDM8_SLOT_W   = 32;
  localparam int unsigned TDM8_PAIRS    = 4;
  localparam int unsigned TDM8_AUX_BITS = 64;

  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;
endpackage

// File: rtl/tdm8_timebase.sv
module tdm8_timebase #(
  parameter int unsigned CNT_W   = 9,
  parameter int unsigned AUX_LOG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nx,
  output logic             tdm_bclk,
  output logic             tdm_fsync,
  output logic             aux_bclk,
  output logic             aux_lrclk,
  output logic             tx_step,
  output logic             rx_step,
  output logic             aux_smp,
  output logic             swap
);
  localparam logic [AUX_LOG-1:0] AUX_SMP_PH = AUX_LOG'((1 << (AUX_LOG - 1)) - 1);

  logic cnt_q;
  logic [CNT_W-1:0] cnt_r;
  logic fsync_q, fsync_nx;

  assign cnt_q    = 1'b1;
  assign cnt_nx   = cnt_r + 1'b1;
  assign fsync_nx = &cnt_nx[CNT_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r   <= '0;
      fsync_q <= 1'b0;
    end else if (cnt_q) begin
      cnt_r   <= cnt_nx;
      fsync_q <= fsync_nx;
    end
  end

  assign cnt       = cnt_r;
  assign tdm_fsync = fsync_q;
  assign tdm_bclk  = ~cnt_r[0];
  assign aux_bclk  = cnt_r[AUX_LOG-1];
  assign aux_lrclk = cnt_r[CNT_W-1];
  assign tx_step   = cnt_r[0];
  assign rx_step   = ~cnt_r[0];
  assign aux_smp   = (cnt_r[AUX_LOG-1:0] == AUX_SMP_PH);
  assign swap      = fsync_nx & ~fsync_q;
endmodule

// File: rtl/tdm8_aux_rx.sv
module tdm8_aux_rx
  import tdm8_pkg::*;
#(
  parameter int unsigned W  = 24,
  parameter int unsigned HW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp,
  input  logic [HW-1:0] hpos,
  input  logic          lr,
  input  logic          sd,
  output logic [W-1:0]  word_l,
  output logic [W-1:0]  word_r
);
  localparam logic [HW-1:0] H_LAST = HW'(W);

  side_e        side;
  logic         take;
  logic [W-1:0] sh_q, sh_nx, l_q, l_nx, r_q, r_nx;

  assign side = side_e'(lr);
  assign take = smp && (hpos != '0) && (hpos <= H_LAST);

  always_comb begin
    sh_nx = sh_q;
    l_nx  = l_q;
    r_nx  = r_q;
    if (take) begin
      sh_nx = {sh_q[W-2:0], sd};
      if (hpos == H_LAST) begin
        if (side == SIDE_L) l_nx = sh_nx;
        else                r_nx = sh_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      l_q  <= '0;
      r_q  <= '0;
    end else begin
      sh_q <= sh_nx;
      l_q  <= l_nx;
      r_q  <= r_nx;
    end
  end

  assign word_l = l_q;
  assign word_r = r_q;
endmodule

// File: rtl/tdm8_play_rx.sv
module tdm8_play_rx #(
  parameter int unsigned W        = 24,
  parameter int unsigned PAIRS    = 4,
  parameter int unsigned SLOT_LOG = 5,
  parameter int unsigned BP_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_step,
  input  logic               swap,
  input  logic [BP_W-1:0]    bitpos,
  input  logic               din,
  output logic [PAIRS*W-1:0] play_l,
  output logic [PAIRS*W-1:0] play_r
);
  localparam int unsigned SLOTS = 2 * PAIRS;
  localparam int unsigned IDX_W = BP_W - SLOT_LOG;
  localparam logic [SLOT_LOG:0]   K_END  = (SLOT_LOG+1)'(W);
  localparam logic [SLOT_LOG-1:0] K_LAST = SLOT_LOG'(W - 1);

  logic [SLOT_LOG-1:0]       k;
  logic [IDX_W-1:0]          s;
  logic [W-1:0]              sh_q, sh_nx;
  logic [SLOTS-1:0][W-1:0]   coll_q, coll_nx, out_q, out_nx;

  assign k = bitpos[SLOT_LOG-1:0];
  assign s = bitpos[BP_W-1:SLOT_LOG];

  always_comb begin
    sh_nx   = sh_q;
    coll_nx = coll_q;
    if (rx_step && ({1'b0, k} < K_END)) begin
      sh_nx = {sh_q[W-2:0], din};
      if (k == K_LAST) coll_nx[s] = sh_nx;
    end
    out_nx = swap ? coll_q : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      coll_q <= '0;
      out_q  <= '0;
    end else begin
      sh_q   <= sh_nx;
      coll_q <= coll_nx;
      out_q  <= out_nx;
    end
  end

  assign play_l = out_q[PAIRS-1:0];
  assign play_r = out_q[SLOTS-1:PAIRS];
endmodule

// File: rtl/tdm8_cap_tx.sv
module tdm8_cap_tx #(
  parameter int unsigned W        = 24,
  parameter int unsigned PAIRS    = 4,
  parameter int unsigned SLOT_LOG = 5,
  parameter int unsigned BP_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tx_step,
  input  logic                   swap,
  input  logic [BP_W-1:0]        bitpos_nx,
  input  logic [W-1:0]           int_l,
  input  logic [W-1:0]           int_r,
  input  logic [(PAIRS-1)*W-1:0] aux_l,
  input  logic [(PAIRS-1)*W-1:0] aux_r,
  output logic                   dout
);
  localparam int unsigned SLOTS = 2 * PAIRS;
  localparam int unsigned IDX_W = BP_W - SLOT_LOG;
  localparam logic [SLOT_LOG:0]   K_END = (SLOT_LOG+1)'(W);
  localparam logic [SLOT_LOG-1:0] K_MSB = SLOT_LOG'(W - 1);

  logic [SLOT_LOG-1:0]     k, bit_sel;
  logic [IDX_W-1:0]        s;
  logic [SLOTS-1:0][W-1:0] hold_q, hold_nx;
  logic                    dout_q, dout_nx;

  assign k       = bitpos_nx[SLOT_LOG-1:0];
  assign s       = bitpos_nx[BP_W-1:SLOT_LOG];
  assign bit_sel = K_MSB - k;

  always_comb begin
    hold_nx = hold_q;
    if (swap) begin
      hold_nx[0]     = int_l;
      hold_nx[PAIRS] = int_r;
      for (int p = 1; p < PAIRS; p++) begin
        hold_nx[p]         = aux_l[(p-1)*W +: W];
        hold_nx[PAIRS + p] = aux_r[(p-1)*W +: W];
      end
    end
    dout_nx = dout_q;
    if (tx_step) dout_nx = ({1'b0, k} < K_END) ? hold_q[s][bit_sel] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      dout_q <= 1'b0;
    end else begin
      hold_q <= hold_nx;
      dout_q <= dout_nx;
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/tdm8_framer.sv
module tdm8_framer
  import tdm8_pkg::*;
#(
  parameter int unsigned SAMPLE_W = TDM8_SAMPLE_W,
  parameter int unsigned SLOT_W   = TDM8_SLOT_W,
  parameter int unsigned PAIRS    = TDM8_PAIRS,
  parameter int unsigned AUX_BITS = TDM8_AUX_BITS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  output logic                        tdm_bclk,
  output logic                        tdm_fsync,
  input  logic                        tdm_din,
  output logic                        tdm_dout,
  output logic                        aux_bclk,
  output logic                        aux_lrclk,
  input  logic [PAIRS-2:0]            aux_sd,
  input  logic [SAMPLE_W-1:0]         cap_int_l,
  input  logic [SAMPLE_W-1:0]         cap_int_r,
  output logic [PAIRS*SAMPLE_W-1:0]   play_l,
  output logic [PAIRS*SAMPLE_W-1:0]   play_r
);
  localparam int unsigned SLOTS      = 2 * PAIRS;
  localparam int unsigned FRAME_BITS = SLOTS * SLOT_W;
  localparam int unsigned CNT_W      = $clog2(2 * FRAME_BITS);
  localparam int unsigned BP_W       = CNT_W - 1;
  localparam int unsigned SLOT_LOG   = $clog2(SLOT_W);
  localparam int unsigned AUX_CLK    = (2 * FRAME_BITS) / AUX_BITS;
  localparam int unsigned AUX_LOG    = $clog2(AUX_CLK);
  localparam int unsigned HW         = CNT_W - 1 - AUX_LOG;
  localparam int unsigned AUX_N      = PAIRS - 1;

  logic [1:0]       rsync_q;
  logic             core_rst_n;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             tx_step, rx_step, aux_smp, swap;
  logic [AUX_N*SAMPLE_W-1:0] aux_l_w, aux_r_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  tdm8_timebase #(.CNT_W(CNT_W), .AUX_LOG(AUX_LOG)) tb_i (
    .clk(clk), .rst_n(core_rst_n), .cnt(cnt), .cnt_nx(cnt_nx),
    .tdm_bclk(tdm_bclk), .tdm_fsync(tdm_fsync), .aux_bclk(aux_bclk),
    .aux_lrclk(aux_lrclk), .tx_step(tx_step), .rx_step(rx_step),
    .aux_smp(aux_smp), .swap(swap)
  );

  for (genvar g = 0; g < AUX_N; g++) begin : g_aux
    tdm8_aux_rx #(.W(SAMPLE_W), .HW(HW)) aux_i (
      .clk(clk), .rst_n(core_rst_n), .smp(aux_smp),
      .hpos(cnt[CNT_W-2:AUX_LOG]), .lr(cnt[CNT_W-1]), .sd(aux_sd[g]),
      .word_l(aux_l_w[g*SAMPLE_W +: SAMPLE_W]),
      .word_r(aux_r_w[g*SAMPLE_W +: SAMPLE_W])
    );
  end

  tdm8_play_rx #(.W(SAMPLE_W), .PAIRS(PAIRS), .SLOT_LOG(SLOT_LOG), .BP_W(BP_W)) prx_i (
    .clk(clk), .rst_n(core_rst_n), .rx_step(rx_step), .swap(swap),
    .bitpos(cnt[CNT_W-1:1]), .din(tdm_din), .play_l(play_l), .play_r(play_r)
  );

  tdm8_cap_tx #(.W(SAMPLE_W), .PAIRS(PAIRS), .SLOT_LOG(SLOT_LOG), .BP_W(BP_W)) ctx_i (
    .clk(clk), .rst_n(core_rst_n), .tx_step(tx_step), .swap(swap),
    .bitpos_nx(cnt_nx[CNT_W-1:1]), .int_l(cap_int_l), .int_r(cap_int_r),
    .aux_l(aux_l_w), .aux_r(aux_r_w), .dout(tdm_dout)
  );
endmodule

// File: rtl/tdm8_framer_chk.sv
module tdm8_framer_chk #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned SLOT_W   = 32,
  parameter int unsigned PAIRS    = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tdm_bclk,
  input logic                      tdm_fsync,
  input logic                      tdm_dout,
  input logic                      aux_bclk,
  input logic                      aux_lrclk,
  input logic [PAIRS*SAMPLE_W-1:0] play_l,
  input logic [PAIRS*SAMPLE_W-1:0] play_r
);
  localparam int unsigned CLK_PER_FRAME = 4 * PAIRS * SLOT_W;
  localparam int unsigned GAP_W = $clog2(CLK_PER_FRAME) + 2;
  localparam logic [GAP_W-1:0] GAP_EXP = GAP_W'(CLK_PER_FRAME - 1);

  logic             fs_q, seen_q;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      fs_q <= tdm_fsync;
      if (tdm_fsync && !fs_q) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R1: one frame between sync pulses
  a_r1_fsync_period: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tdm_fsync) |-> (!seen_q || gap_q == GAP_EXP));

  // R1: pulse is one bit period (two master clocks) wide
  a_r1_fsync_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tdm_fsync) |=> (tdm_fsync ##1 !tdm_fsync));

  // R2: serial capture data moves only with the rising bit clock
  a_r2_dout_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tdm_dout) |-> $rose(tdm_bclk));

  // R3: auxiliary word clock turns only with a falling auxiliary bit clock
  a_r3_lr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(aux_lrclk) |-> $fell(aux_bclk));

  // R8: playback words change only at the frame sync rise
  a_r8_play_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(play_l) || !$stable(play_r)) |-> $rose(tdm_fsync));
endmodule

bind tdm8_framer tdm8_framer_chk #(
  .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .PAIRS(PAIRS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tdm_bclk(tdm_bclk), .tdm_fsync(tdm_fsync),
  .tdm_dout(tdm_dout), .aux_bclk(aux_bclk), .aux_lrclk(aux_lrclk),
  .play_l(play_l), .play_r(play_r)
);

// File: tb/tdm8_framer_tb_top.sv
module tdm8_framer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W     = 24;
  localparam int PAIRS = 4;
  localparam int SLOTS = 8;

  logic clk, rst_n, tdm_bclk, tdm_fsync, tdm_din, tdm_dout, aux_bclk, aux_lrclk;
  logic [2:0] aux_sd;
  logic [W-1:0] cap_int_l, cap_int_r;
  logic [PAIRS*W-1:0] play_l, play_r;

  tdm8_framer dut_i (
    .clk(clk), .rst_n(rst_n), .tdm_bclk(tdm_bclk), .tdm_fsync(tdm_fsync),
    .tdm_din(tdm_din), .tdm_dout(tdm_dout), .aux_bclk(aux_bclk),
    .aux_lrclk(aux_lrclk), .aux_sd(aux_sd), .cap_int_l(cap_int_l),
    .cap_int_r(cap_int_r), .play_l(play_l), .play_r(play_r)
  );

  int n_chk = 0;
  int n_fail = 0;
  int dout_unstable = 0;
  logic [W-1:0] tx_words [SLOTS];
  logic [31:0]  rx_raw [SLOTS];
  logic [W-1:0] aux_l_v [3];
  logic [W-1:0] aux_r_v [3];
  logic [PAIRS*W-1:0] mid_l, mid_r;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    report();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // auxiliary I2S sources: change data on falling aux bit clock
  initial begin
    int pos;
    logic lr_prev;
    pos = 0;
    lr_prev = 1'b0;
    aux_sd = '1;
    forever begin
      @(negedge aux_bclk);
      #1;
      if (aux_lrclk !== lr_prev) pos = 0;
      else pos++;
      lr_prev = aux_lrclk;
      for (int i = 0; i < 3; i++) begin
        if (pos >= 1 && pos <= W)
          aux_sd[i] = aux_lrclk ? aux_r_v[i][W-pos] : aux_l_v[i][W-pos];
        else
          aux_sd[i] = 1'b1;
      end
    end
  end

  task automatic sync_frame();
    do begin
      @(negedge tdm_bclk);
      #1;
    end while (tdm_fsync !== 1'b1);
    @(posedge tdm_bclk);
    #1;
  endtask

  // one full frame from bit 0; leaves at bit 0 of the next frame
  task automatic run_frame();
    logic first;
    for (int b = 0; b < 256; b++) begin
      int s, k;
      s = b / 32;
      k = b % 32;
      tdm_din = (k < W) ? tx_words[s][W-1-k] : k[0];
      first = tdm_dout;
      @(negedge tdm_bclk);
      #1;
      if (tdm_dout !== first) dout_unstable++;
      rx_raw[s][31-k] = tdm_dout;
      if (b == 128) begin
        mid_l = play_l;
        mid_r = play_r;
      end
      @(posedge tdm_bclk);
      #1;
    end
  endtask

  function automatic logic [W-1:0] exp_cap(input int s);
    int p;
    bit right;
    p = s % PAIRS;
    right = (s >= PAIRS);
    if (p == 0) return right ? cap_int_r : cap_int_l;
    return right ? aux_r_v[p-1] : aux_l_v[p-1];
  endfunction

  task automatic check_capture();
    for (int s = 0; s < SLOTS; s++) begin
      if (s % PAIRS == 0)
        chk(rx_raw[s][31:8] == exp_cap(s), "R5 internal word in slot", rx_raw[s][31:8], exp_cap(s));
      else
        chk(rx_raw[s][31:8] == exp_cap(s), "R9 aux word in slot (R5 order)", rx_raw[s][31:8], exp_cap(s));
      chk(rx_raw[s][7:0] == 8'h00, "R6 pad bits zero", rx_raw[s][7:0], 8'h00);
    end
    chk(dout_unstable == 0, "R2 dout stable within bit", dout_unstable, 0);
  endtask

  task automatic t_reset_state();
    chk(tdm_bclk === 1'b1, "R10 bclk in reset", tdm_bclk, 1);
    chk({tdm_fsync, tdm_dout, aux_bclk, aux_lrclk} === 4'b0, "R10 outputs low in reset",
        {tdm_fsync, tdm_dout, aux_bclk, aux_lrclk}, 0);
    chk(play_l === '0 && play_r === '0, "R10 play ports zero", {play_l, play_r}, 0);
  endtask

  task automatic t_frame_sync();
    int bad;
    bad = 0;
    sync_frame();
    for (int b = 0; b < 512; b++) begin
      @(negedge tdm_bclk);
      #1;
      if (tdm_fsync !== ((b % 256) == 255)) bad++;
      @(posedge tdm_bclk);
      #1;
    end
    chk(bad == 0, "R1 fsync only in bit 255", bad, 0);
  endtask

  task automatic t_aux_clocks();
    int rises, lrbad;
    logic prev;
    rises = 0;
    lrbad = 0;
    sync_frame();
    prev = aux_bclk;
    for (int b = 0; b < 256; b++) begin
      @(negedge tdm_bclk);
      #1;
      if (aux_bclk && !prev) rises++;
      prev = aux_bclk;
      if (aux_lrclk !== (b >= 128)) lrbad++;
      @(posedge tdm_bclk);
      #1;
    end
    chk(rises == 64, "R3 aux bclk rises per frame", rises, 64);
    chk(lrbad == 0, "R3 aux lrclk low first half", lrbad, 0);
  endtask

  task automatic set_play(input logic [W-1:0] seed);
    for (int s = 0; s < SLOTS; s++)
      tx_words[s] = seed ^ (24'h111111 * W'(s + 1));
  endtask

  task automatic check_play(input string req);
    for (int p = 0; p < PAIRS; p++) begin
      chk(play_l[p*W +: W] == tx_words[p], req, play_l[p*W +: W], tx_words[p]);
      chk(play_r[p*W +: W] == tx_words[PAIRS+p], req, play_r[p*W +: W], tx_words[PAIRS+p]);
    end
  endtask

  task automatic t_playback();
    logic [PAIRS*W-1:0] old_l, old_r;
    set_play(24'hA5C30F);
    sync_frame();
    old_l = play_l;
    old_r = play_r;
    run_frame();
    chk(mid_l == old_l && mid_r == old_r, "R8 play held mid-frame", mid_l, old_l);
    check_play("R4 playback slot order, pad ignored");
    old_l = play_l;
    set_play(24'h5A3CF0);
    run_frame();
    chk(mid_l == old_l, "R8 play held until fsync", mid_l, old_l);
    check_play("R4 second playback pattern");
  endtask

  task automatic t_capture(input logic [W-1:0] il, input logic [W-1:0] ir,
                           input logic [W-1:0] base);
    cap_int_l = il;
    cap_int_r = ir;
    for (int i = 0; i < 3; i++) begin
      aux_l_v[i] = base ^ (24'h0F0F01 * W'(i + 1));
      aux_r_v[i] = ~base ^ (24'h010203 * W'(i + 5));
    end
    sync_frame();
    run_frame();
    run_frame();
    dout_unstable = 0;
    run_frame();
    check_capture();
  endtask

  task automatic t_latency();
    cap_int_l = 24'h123456;
    cap_int_r = 24'h654321;
    sync_frame();
    run_frame();
    run_frame();
    cap_int_l = 24'hABCDEF;
    cap_int_r = 24'hFEDCBA;
    run_frame();
    chk(rx_raw[0][31:8] == 24'h123456, "R7 frame in progress keeps old left", rx_raw[0][31:8], 24'h123456);
    chk(rx_raw[4][31:8] == 24'h654321, "R7 frame in progress keeps old right", rx_raw[4][31:8], 24'h654321);
    run_frame();
    chk(rx_raw[0][31:8] == 24'hABCDEF, "R7 next frame carries new left", rx_raw[0][31:8], 24'hABCDEF);
    chk(rx_raw[4][31:8] == 24'hFEDCBA, "R7 next frame carries new right", rx_raw[4][31:8], 24'hFEDCBA);
  endtask

  initial begin
    rst_n = 1'b0;
    tdm_din = 1'b0;
    cap_int_l = '0;
    cap_int_r = '0;
    for (int s = 0; s < SLOTS; s++) tx_words[s] = '0;
    for (int i = 0; i < 3; i++) begin
      aux_l_v[i] = '0;
      aux_r_v[i] = '0;
    end
    repeat (4) @(posedge clk);
    #1;
    t_reset_state();
    rst_n = 1'b1;
    t_frame_sync();
    t_aux_clocks();
    t_playback();
    t_capture(24'h800000, 24'h7FFFFF, 24'h000001);
    t_capture(24'h00FF00, 24'hFF00FF, 24'hC3A596);
    t_latency();
    report();
    $finish;
  end
endmodule